// File: doc/BRIEF.md
# Protected Watchdog Timer

This block is a watchdog that counts ticks from a companion timer and raises a one-cycle system reset pulse when software stops servicing it. Each tick goes through a prescaler whose ratio is a power of two set by a 3-bit period field. The prescaler advances a 3-bit stage counter, and the reset pulse fires when that counter wraps. Software restarts the count by pulsing a service strobe. It can also clear the counter by disabling the watchdog, and the counter is held at zero while the watchdog is off.

An 8-bit control register holds the enable bit, the period field and a change-enable flag. Clearing the enable bit or changing the period while the watchdog runs needs an unlock sequence. Software first writes a value with both the change-enable and enable bits set, which opens a window of four cycles. Exactly one write inside that window may then clear the enable bit or load a new period. A fuse input picks the safety level. At level 1 the watchdog starts off and can be turned off through the window. At level 2 it starts on and can never be turned off, but its period can still be changed through the window.

Top module: `wdt_guard`

## Requirements
- R1: After reset the register reads 0x00 when the fuse is low (level 1) and 0x08 when the fuse is high (level 2). The enable bit is bit 3.
- R2: Register bits 7 to 5 always read zero. Bit 4 reads the change-enable flag, bit 3 the enable bit and bits 2 to 0 the period select.
- R3: With the watchdog enabled and period select s, the reset output goes high in the cycle after the (8·2^s)-th tick counted since the last clear.
- R4: The reset output is high for exactly one cycle. The count then restarts from zero, so the next pulse comes after another full period.
- R5: The service strobe clears the count and wins over a tick in the same cycle.
- R6: While the watchdog is disabled the count is held at zero and no reset pulse is produced.
- R7: A write with bits 4 and 3 both set, made while the window is closed, opens the window. Bit 4 then reads one for four cycles and clears by itself.
- R8: A zero written to bit 3 takes effect only on a write inside the window. Outside the window, and after the window has expired, such a write leaves the enable bit unchanged.
- R9: While the watchdog is enabled, a new period select is accepted only on a write inside the window and is otherwise ignored. An accepted period change clears the count.
- R10: At level 1, while the watchdog is disabled, the period select may be written freely, and writing one to bit 3 enables the watchdog at any time.
- R11: At level 2 the enable bit stays one, even when zero is written to it inside the window. A period change inside the window is still accepted.
- R12: The first write inside the window uses it up, so bit 4 reads zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Chip reset, active low |
| fuseLocked | input | 1 | Safety fuse, 1 selects level 2 |
| wdTick | input | 1 | One-cycle tick from the timer's watchdog clock output |
| kick | input | 1 | Watchdog service strobe from software |
| regWe | input | 1 | Control register write strobe |
| regWdata | input | 8 | Control register write data |
| regRdata | output | 8 | Control register read data |
| sysReset | output | 1 | One-cycle system reset request |

## Verification
The timeout is measured for all eight period selects with a continuous tick stream, which tells a wrong prescaler ratio apart from an off-by-one in the stage counter. Back-to-back periods confirm the restart after the pulse. Ticks interrupted by a service strobe, or by a period change, separate a real clear from a count that merely keeps running. Register writes are placed before the window opens, on its last cycle and one cycle after it closes. This distinguishes a window that is too short or too long from one whose protected fields ignore the unlock. The fuse-high runs show that level 2 blocks the disable while still letting the period be changed.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic             clearCnt;
    logic             runCnt;
    logic [SEL_W-1:0] periodSel;
  } wdStrobes_t;
endpackage

// File: rtl/wdt_guard_ctl.sv
module wdt_guard_ctl
  import wdt_guard_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int WIN_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fuseLocked,
  input  logic              kick,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output wdStrobes_t        strb
);
  localparam int EN_BIT = SEL_W;
  localparam int CE_BIT = SEL_W + 1;
  localparam int WIN_W  = $clog2(WIN_CYCLES + 1);

  logic             enableQ, enableN;
  logic [SEL_W-1:0] selQ, selN;
  logic [WIN_W-1:0] winCnt, winN;
  logic             windowOpen, wrOpen, wrProt, wrPlain, freeSel;
  logic             unusedBits;

  assign unusedBits = ^regWdata[DATA_W-1:CE_BIT+1];
  assign windowOpen = (winCnt != '0);
  assign wrOpen     = regWe && !windowOpen && regWdata[CE_BIT] && regWdata[EN_BIT];
  assign wrProt     = regWe && windowOpen;
  assign wrPlain    = regWe && !windowOpen && !wrOpen;
  assign freeSel    = !fuseLocked && !enableQ;

  always_comb begin
    enableN = enableQ;
    selN    = selQ;
    winN    = windowOpen ? winCnt - WIN_W'(1) : '0;
    if (wrOpen) begin
      winN    = WIN_W'(WIN_CYCLES);
      enableN = 1'b1;
      if (freeSel) selN = regWdata[SEL_W-1:0];
    end else if (wrProt) begin
      winN    = '0;
      enableN = fuseLocked ? 1'b1 : regWdata[EN_BIT];
      selN    = regWdata[SEL_W-1:0];
    end else if (wrPlain) begin
      if (regWdata[EN_BIT]) enableN = 1'b1;
      if (freeSel) selN = regWdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= fuseLocked;
      selQ    <= '0;
      winCnt  <= '0;
    end else begin
      enableQ <= enableN;
      selQ    <= selN;
      winCnt  <= winN;
    end
  end

  assign strb.clearCnt  = !enableQ || kick || (selN != selQ);
  assign strb.runCnt    = enableQ;
  assign strb.periodSel = selQ;

  always_comb begin
    regRdata                = '0;
    regRdata[CE_BIT]        = windowOpen;
    regRdata[EN_BIT]        = enableQ;
    regRdata[SEL_W-1:0]     = selQ;
  end

  // R7
  win_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(windowOpen) |-> $past(regWe && regWdata[CE_BIT] && regWdata[EN_BIT]));

  // R8
  disable_in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enableQ) |-> $past(windowOpen && regWe));

  // R11
  locked_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    fuseLocked |-> enableQ);

  // R9
  sel_protect_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enableQ) && !$past(windowOpen)) |-> $stable(selQ));
endmodule

// File: rtl/wdt_guard_dp.sv
module wdt_guard_dp
  import wdt_guard_pkg::*;
#(
  parameter int STAGE_W = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wdTick,
  input  wdStrobes_t strb,
  output logic       sysReset
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0]   preCnt, preLimit;
  logic [STAGE_W-1:0] stageCnt;
  logic               stepStage, wrap;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) preLimit[i] = (i < int'(strb.periodSel));
  end

  assign stepStage = strb.runCnt && wdTick && (preCnt == preLimit);
  assign wrap      = stepStage && (stageCnt == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      stageCnt <= '0;
      sysReset <= 1'b0;
    end else if (strb.clearCnt) begin
      preCnt   <= '0;
      stageCnt <= '0;
      sysReset <= 1'b0;
    end else begin
      sysReset <= wrap;
      if (strb.runCnt && wdTick) begin
        preCnt <= stepStage ? '0 : preCnt + PRE_W'(1);
        if (stepStage) stageCnt <= stageCnt + STAGE_W'(1);
      end
    end
  end

  // R4
  one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysReset |=> !sysReset);

  // R3
  wrap_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysReset |-> ($past(stageCnt) == '1 && $past(wdTick) && stageCnt == '0));

  // R6
  clear_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCnt |=> (stageCnt == '0 && preCnt == '0 && !sysReset));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int WIN_CYCLES = 4,
  parameter int STAGE_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fuseLocked,
  input  logic              wdTick,
  input  logic              kick,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              sysReset
);
  wdStrobes_t strb;

  wdt_guard_ctl #(.DATA_W(DATA_W), .WIN_CYCLES(WIN_CYCLES)) ctl (
    .clk(clk), .rstN(rstN), .fuseLocked(fuseLocked), .kick(kick),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata), .strb(strb)
  );

  wdt_guard_dp #(.STAGE_W(STAGE_W)) dp (
    .clk(clk), .rstN(rstN), .wdTick(wdTick), .strb(strb), .sysReset(sysReset)
  );
endmodule

// File: tb/wdt_guard_test.sv
`timescale 1ns/1ps
module wdt_guard_test;
  logic clk = 1'b0, rstN = 1'b0, fuseLocked = 1'b0, wdTick = 1'b0, kick = 1'b0, regWe = 1'b0;
  logic [7:0] regWdata = '0, regRdata;
  logic sysReset;
  int tests = 0, fails = 0;
  bit finished = 0;

  localparam logic [7:0] WR_VAL [8] = '{8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F};
  localparam int EXP_TICKS [8] = '{8, 16, 32, 64, 128, 256, 512, 1024};

  wdt_guard uut (.clk(clk), .rstN(rstN), .fuseLocked(fuseLocked), .wdTick(wdTick), .kick(kick),
                 .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata), .sysReset(sysReset));

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic doReset(input logic f);
    rstN = 1'b0; fuseLocked = f; idle(2); rstN = 1'b1; idle(1);
  endtask

  task automatic wrReg(input logic [7:0] d);
    regWe = 1'b1; regWdata = d; @(posedge clk); #1; regWe = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0; wdTick = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1; n++;
      if (sysReset) break;
    end
    wdTick = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run hung, actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    int pulses;
    doReset(1'b0);
    check("R1 level1 reset value", regRdata, 8'h00);
    check("R6 no pulse while off", sysReset, 0);

    // R3 R4 R10: table walk over all selects
    for (int k = 0; k < 8; k++) begin
      doReset(1'b0);
      wrReg(WR_VAL[k]);
      check("R10 free select while off", regRdata, WR_VAL[k]);
      measure(n);
      check("R3 timeout ticks", n, EXP_TICKS[k]);
      idle(1);
      check("R4 pulse one cycle", sysReset, 0);
      measure(n);
      check("R4 restart full period", n, EXP_TICKS[k]);
      idle(1);
    end

    // R5 service strobe
    doReset(1'b0);
    wrReg(8'h08);
    wdTick = 1'b1; idle(5);
    kick = 1'b1; idle(1); kick = 1'b0; wdTick = 1'b0;
    measure(n);
    check("R5 kick restarts count", n, 8);
    idle(1);

    // R8 R9 outside window
    wrReg(8'h0A);
    check("R9 select locked while on", regRdata, 8'h08);
    doReset(1'b0);
    wrReg(8'h0A);
    wrReg(8'h00);
    check("R8 disable outside window ignored", regRdata, 8'h0A);
    wrReg(8'h0B);
    check("R9 select change outside window ignored", regRdata, 8'h0A);
    wrReg(8'hE8);
    check("R2 reserved bits read zero", regRdata, 8'h0A);

    // R7 R8 R12 window disable on last cycle
    wrReg(8'h18);
    check("R7 window opens", regRdata, 8'h1A);
    idle(3);
    check("R7 window still open", regRdata, 8'h1A);
    wrReg(8'h00);
    check("R8 disable in window accepted", regRdata, 8'h00);
    check("R12 window closed after use", regRdata[4], 0);
    pulses = 0; wdTick = 1'b1;
    for (int i = 0; i < 300; i++) begin @(posedge clk); #1; if (sysReset) pulses++; end
    wdTick = 1'b0;
    check("R6 disabled gives no pulses", pulses, 0);

    // R7 R8 expiry
    wrReg(8'h0A);
    wrReg(8'h18);
    idle(3);
    check("R7 open before expiry", regRdata, 8'h1A);
    idle(1);
    check("R7 window self-clears", regRdata, 8'h0A);
    wrReg(8'h00);
    check("R8 disable after expiry ignored", regRdata, 8'h0A);

    // R9 window period change clears count
    wdTick = 1'b1; idle(20); wdTick = 1'b0;
    wrReg(8'h18);
    wrReg(8'h08);
    check("R9 select change in window", regRdata, 8'h08);
    measure(n);
    check("R9 period change clears count", n, 8);
    idle(1);

    // R1 R11 level 2
    doReset(1'b1);
    check("R1 level2 reset value", regRdata, 8'h08);
    wrReg(8'h00);
    check("R11 disable outside window ignored", regRdata, 8'h08);
    wrReg(8'h18);
    wrReg(8'h00);
    check("R11 disable in window blocked", regRdata, 8'h08);
    measure(n);
    check("R11 still counting", n, 8);
    idle(1);
    wrReg(8'h18);
    wrReg(8'h03);
    check("R11 select change in window", regRdata, 8'h0B);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule